// File: doc/BRIEF.md
# Packed Pixel Line Unpacker

This block turns a stream of 32-bit frame-buffer words for one display line into a stream of 24-bit RGB pixels. It emits one pixel per handshake on a valid/ready output. The pixel depth, the byte ordering, the pixel ordering inside a byte and a red/blue exchange all come from a control word. Depths of 8 bits or less give a palette index, which is looked up in a 256-entry colour table loaded through a write port. Depths of 16 and 32 bits carry the colour directly.

The line is started by a `line_go` pulse, which captures the control word and the column count. After that, the block pulls words and pushes pixels until exactly the requested number of pixels have left. Two combinational helpers are also provided:
- the number of source bytes in one line, computed from the live column count and depth;
- the frame base address with its upper alias folded away.

The sequencer has three states:
- `S_IDLE`, waiting for a start.
- `S_FETCH`, waiting for a word.
- `S_EMIT`, presenting pixels of the held word.

It has these transitions:
- start (`S_IDLE` to `S_FETCH`, on `line_go` with a non-zero column count);
- word taken (`S_FETCH` to `S_EMIT`);
- word drained (`S_EMIT` to `S_FETCH`, when the last pixel of a word leaves and no new word is offered);
- back-to-back reload (`S_EMIT` stays in `S_EMIT`, when a new word is taken in the same cycle);
- line done (`S_EMIT` to `S_IDLE`, on the final pixel).

Top module: `line_unpacker`

## Requirements
- R1: After reset, `pix_vld` and `word_rdy` are low and stay low until a line is started.
- R2: The depth field is `ctrl_word[3:1]`. Codes 0 to 5 select 1, 2, 4, 8, 16 and 32 bits per pixel, and codes 6 and 7 behave as code 5.
- R3: With `ctrl_word[9]` and `ctrl_word[10]` both clear, pixel k of a word is taken from bits [k*bpp +: bpp].
- R4: With `ctrl_word[9]` set, the order is big-endian: pixel k of a word is taken from bits [32-(k+1)*bpp +: bpp]. This holds whatever `ctrl_word[10]` is.
- R5: With only `ctrl_word[10]` set, bytes are taken from least significant upward. For depths below 8, pixels inside each byte start at its most significant end. At 8, 16 and 32 bits the order is that of R3.
- R6: At depths of 8 or less, the pixel field, zero-extended, indexes the palette. A palette entry holds red in [23:16], green in [15:8] and blue in [7:0], and is written through `pal_we`/`pal_addr`/`pal_wdata`.
- R7: At 16 bits, red is field[4:0], green is field[10:5] and blue is field[15:11], each shifted up to 8 bits with zero fill. At 32 bits, red is field[7:0], green is field[15:8] and blue is field[23:16]; field[31:24] is ignored.
- R8: With `ctrl_word[8]` set, the red and blue channels of every output pixel are exchanged.
- R9: A line emits exactly `line_cols` pixels, and `pix_last` is high only on the final one. Unused pixels of the final word are discarded, and the next line begins with a fresh word.
- R10: While `pix_vld` is high and `pix_rdy` is low, the pixel and `pix_last` hold, and no word is accepted.
- R11: `line_bytes` is the column count divided by 8, 4 and 2 at depth codes 0, 1 and 2. It equals the column count at code 3, and is twice or four times it at code 4 and at codes 5 to 7.
- R12: `frame_addr` is `base_addr` minus 0x80000000 when `base_addr` is strictly above 0x80000000, and `base_addr` unchanged otherwise.
- R13: With words always offered and `pix_rdy` always high, a line's pixels leave on consecutive cycles, and a new word is taken in the cycle the previous word's last pixel leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 11 | Depth [3:1], red/blue exchange [8], big-endian bytes [9], big-endian pixels [10] |
| line_cols | input | 12 | Pixels in the line |
| line_go | input | 1 | Start pulse; captures ctrl_word and line_cols |
| base_addr | input | 32 | Frame base address |
| frame_addr | output | 32 | Base address after alias fold |
| line_bytes | output | 14 | Source bytes per line |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 8 | Palette write index |
| pal_wdata | input | 24 | Palette colour {R,G,B} |
| word_data | input | 32 | Frame data word |
| word_vld | input | 1 | Word valid |
| word_rdy | output | 1 | Word accepted when high with word_vld |
| pix_rdy | input | 1 | Downstream ready |
| pix_vld | output | 1 | Pixel valid |
| pix_rgb | output | 24 | Pixel colour {R,G,B} |
| pix_last | output | 1 | Final pixel of the line |

## Verification
The assertions check, on every cycle, the handshake rules:
- a stalled pixel holds its colour and its last flag;
- the sequencer returns to idle after a final pixel;
- the pixel counter stays below the captured column count;
- a pixel never appears without a word having been accepted;
- the folded address never exceeds the base.

They also check that the ordering decode is one-hot and that back-to-back words keep the stream unbroken. Only the bench scenarios can show that the right field lands in the right pixel for each depth and ordering, and that the palette and direct colour maps and the channel exchange give the right colour. The same holds for the bytes-per-line arithmetic and for words being discarded across line boundaries.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

    localparam int CTRL_W         = 11;
    localparam int DEPTH_LSB      = 1;
    localparam int SWAP_BIT       = 8;
    localparam int BE_BYTE_BIT    = 9;
    localparam int BE_PIX_BIT     = 10;
    localparam int DEPTH_MAX_CODE = 5;

    typedef enum logic [2:0] {
        ORD_LE  = 3'b001,
        ORD_BEB = 3'b010,
        ORD_BEP = 3'b100
    } order_e;

    typedef struct packed {
        logic [2:0] depth;
        order_e     order;
        logic       swap;
    } line_cfg_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_EMIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/lpu_cfg_decode.sv
module lpu_cfg_decode
    import lpu_pkg::*;
#(
    parameter int COL_W  = 12,
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h8000_0000
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [COL_W-1:0]  line_cols,
    input  logic [ADDR_W-1:0] base_addr,
    output line_cfg_t         cfg,
    output logic [COL_W+1:0]  line_bytes,
    output logic [ADDR_W-1:0] frame_addr
);

    logic [2:0]       raw_depth;
    logic [COL_W+1:0] cols_ext;

    assign raw_depth = ctrl_word[DEPTH_LSB +: 3];
    assign cols_ext  = {2'b00, line_cols};

    // depth normalisation and ordering priority: byte order wins
    always_comb begin
        cfg.depth = (raw_depth > 3'(DEPTH_MAX_CODE)) ? 3'(DEPTH_MAX_CODE) : raw_depth;
        cfg.swap  = ctrl_word[SWAP_BIT];
        if (ctrl_word[BE_BYTE_BIT]) begin
            cfg.order = ORD_BEB;
        end else if (ctrl_word[BE_PIX_BIT]) begin
            cfg.order = ORD_BEP;
        end else begin
            cfg.order = ORD_LE;
        end
    end

    always_comb begin
        unique case (cfg.depth)
            3'd0:    line_bytes = cols_ext >> 3;
            3'd1:    line_bytes = cols_ext >> 2;
            3'd2:    line_bytes = cols_ext >> 1;
            3'd3:    line_bytes = cols_ext;
            3'd4:    line_bytes = cols_ext << 1;
            default: line_bytes = cols_ext << 2;
        endcase
    end

    assign frame_addr = (base_addr > ALIAS_BASE) ? (base_addr - ALIAS_BASE) : base_addr;

endmodule

// File: rtl/lpu_palette.sv
module lpu_palette #(
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 24
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [COLOR_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr,
    output logic [COLOR_W-1:0] rdata
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [COLOR_W-1:0] table_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            table_q[waddr] <= wdata;
        end
    end

    assign rdata = table_q[raddr];

endmodule

// File: rtl/lpu_word_fsm.sv
module lpu_word_fsm
    import lpu_pkg::*;
#(
    parameter int COL_W  = 12,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_go,
    input  logic [COL_W-1:0]  line_cols,
    input  line_cfg_t         cfg_in,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_vld,
    output logic              word_rdy,
    input  logic              pix_rdy,
    output logic              pix_vld,
    output logic              pix_last,
    output logic [WORD_W-1:0] field,
    output line_cfg_t         cfg_q
);

    localparam int SLOT_W = $clog2(WORD_W);

    seq_state_e        st_q, st_d;
    logic [WORD_W-1:0] word_q;
    logic [SLOT_W-1:0] slot_q;
    logic [COL_W-1:0]  cnt_q;
    logic [COL_W-1:0]  cols_q;

    logic              start, load_word, adv_slot, step;
    logic              slot_end, pix_end;

    logic [5:0]        bpp;
    logic [SLOT_W-1:0] le_off, off, ppw_m1;
    logic [WORD_W-1:0] mask;

    // field geometry from the captured depth
    assign bpp      = 6'd1 << cfg_q.depth;
    assign ppw_m1   = SLOT_W'((6'd32 >> cfg_q.depth) - 6'd1);
    assign le_off   = slot_q << cfg_q.depth;
    assign mask     = {WORD_W{1'b1}} >> (6'd32 - bpp);
    assign slot_end = (slot_q == ppw_m1);
    assign pix_end  = (cnt_q == cols_q - COL_W'(1));

    always_comb begin
        unique case (cfg_q.order)
            ORD_BEB: off = le_off ^ SLOT_W'(6'd32 - bpp);
            ORD_BEP: off = (cfg_q.depth < 3'd3) ? (le_off ^ SLOT_W'(6'd8 - bpp)) : le_off;
            default: off = le_off;
        endcase
    end

    assign field = (word_q >> off) & mask;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and handshake outputs
    always_comb begin
        st_d      = st_q;
        start     = 1'b0;
        load_word = 1'b0;
        adv_slot  = 1'b0;
        step      = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (line_go && (line_cols != '0)) begin
                    st_d  = S_FETCH;
                    start = 1'b1;
                end
            end
            S_FETCH: begin
                if (word_vld) begin
                    st_d      = S_EMIT;
                    load_word = 1'b1;
                end
            end
            S_EMIT: begin
                if (pix_rdy) begin
                    step = 1'b1;
                    if (pix_end) begin
                        st_d = S_IDLE;
                    end else if (slot_end) begin
                        if (word_vld) begin
                            load_word = 1'b1;
                        end else begin
                            st_d = S_FETCH;
                        end
                    end else begin
                        adv_slot = 1'b1;
                    end
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    assign word_rdy = (st_q == S_FETCH) ||
                      ((st_q == S_EMIT) && pix_rdy && slot_end && !pix_end);
    assign pix_vld  = (st_q == S_EMIT);
    assign pix_last = pix_vld && pix_end;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            slot_q <= '0;
            cnt_q  <= '0;
            cols_q <= '0;
            cfg_q  <= '{depth: 3'd0, order: ORD_LE, swap: 1'b0};
        end else begin
            if (start) begin
                cfg_q  <= cfg_in;
                cols_q <= line_cols;
                cnt_q  <= '0;
            end else if (step) begin
                cnt_q  <= cnt_q + COL_W'(1);
            end
            if (load_word) begin
                word_q <= word_data;
                slot_q <= '0;
            end else if (adv_slot) begin
                slot_q <= slot_q + SLOT_W'(1);
            end
        end
    end

    // R9
    last_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld && pix_rdy && pix_last |=> !pix_vld);

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> (cnt_q < cols_q));

    // R9
    pix_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_vld) |-> $past(word_vld && word_rdy));

    // R4
    order_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE) |-> $onehot(cfg_q.order));

    // R13
    reload_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld && pix_rdy && !pix_last && word_vld && word_rdy |=> pix_vld);

endmodule

// File: rtl/lpu_color_path.sv
module lpu_color_path
    import lpu_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int IDX_W   = 8,
    parameter int CHAN_W  = 8
) (
    input  logic [WORD_W-1:0]   field,
    input  line_cfg_t           cfg,
    output logic [IDX_W-1:0]    pal_idx,
    input  logic [3*CHAN_W-1:0] pal_color,
    output logic [3*CHAN_W-1:0] rgb
);

    logic [CHAN_W-1:0] red, grn, blu;
    logic              unused_hi;

    assign pal_idx   = field[IDX_W-1:0];
    assign unused_hi = &{1'b0, field[WORD_W-1:3*CHAN_W]};

    always_comb begin
        unique case (cfg.depth)
            3'd4: begin
                red = {field[4:0],   3'b000};
                grn = {field[10:5],  2'b00};
                blu = {field[15:11], 3'b000};
            end
            3'd5: begin
                red = field[7:0];
                grn = field[15:8];
                blu = field[23:16];
            end
            default: begin
                red = pal_color[3*CHAN_W-1:2*CHAN_W];
                grn = pal_color[2*CHAN_W-1:CHAN_W];
                blu = pal_color[CHAN_W-1:0];
            end
        endcase
    end

    assign rgb = cfg.swap ? {blu, grn, red} : {red, grn, blu};

endmodule

// File: rtl/line_unpacker.sv
module line_unpacker
    import lpu_pkg::*;
#(
    parameter int COL_W  = 12,
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 8,
    parameter int CHAN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CTRL_W-1:0]   ctrl_word,
    input  logic [COL_W-1:0]    line_cols,
    input  logic                line_go,
    input  logic [ADDR_W-1:0]   base_addr,
    output logic [ADDR_W-1:0]   frame_addr,
    output logic [COL_W+1:0]    line_bytes,
    input  logic                pal_we,
    input  logic [IDX_W-1:0]    pal_addr,
    input  logic [3*CHAN_W-1:0] pal_wdata,
    input  logic [WORD_W-1:0]   word_data,
    input  logic                word_vld,
    output logic                word_rdy,
    input  logic                pix_rdy,
    output logic                pix_vld,
    output logic [3*CHAN_W-1:0] pix_rgb,
    output logic                pix_last
);

    localparam int COLOR_W = 3 * CHAN_W;

    line_cfg_t          cfg_live, cfg_held;
    logic [WORD_W-1:0]  field;
    logic [IDX_W-1:0]   pal_idx;
    logic [COLOR_W-1:0] pal_color;

    lpu_cfg_decode #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_decode (
        .ctrl_word  (ctrl_word),
        .line_cols  (line_cols),
        .base_addr  (base_addr),
        .cfg        (cfg_live),
        .line_bytes (line_bytes),
        .frame_addr (frame_addr)
    );

    lpu_word_fsm #(.COL_W(COL_W), .WORD_W(WORD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_go   (line_go),
        .line_cols (line_cols),
        .cfg_in    (cfg_live),
        .word_data (word_data),
        .word_vld  (word_vld),
        .word_rdy  (word_rdy),
        .pix_rdy   (pix_rdy),
        .pix_vld   (pix_vld),
        .pix_last  (pix_last),
        .field     (field),
        .cfg_q     (cfg_held)
    );

    lpu_palette #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_pal (
        .clk   (clk),
        .we    (pal_we),
        .waddr (pal_addr),
        .wdata (pal_wdata),
        .raddr (pal_idx),
        .rdata (pal_color)
    );

    lpu_color_path #(.WORD_W(WORD_W), .IDX_W(IDX_W), .CHAN_W(CHAN_W)) u_color (
        .field     (field),
        .cfg       (cfg_held),
        .pal_idx   (pal_idx),
        .pal_color (pal_color),
        .rgb       (pix_rgb)
    );

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld && !pix_rdy && !pal_we |=> pix_vld && $stable(pix_rgb) && $stable(pix_last));

    // R10
    stall_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld && !pix_rdy |-> !word_rdy);

    // R12
    fold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_addr <= base_addr) && (!frame_addr[ADDR_W-1] || (frame_addr == base_addr)));

endmodule

// File: tb/line_unpacker_tb.sv
module line_unpacker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ctrl_word = '0;
    logic [11:0] line_cols = '0;
    logic        line_go = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] frame_addr;
    logic [13:0] line_bytes;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_addr = '0;
    logic [23:0] pal_wdata = '0;
    logic [31:0] word_data = '0;
    logic        word_vld = 1'b0;
    logic        word_rdy;
    logic        pix_rdy = 1'b0;
    logic        pix_vld;
    logic [23:0] pix_rgb;
    logic        pix_last;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] seed = 32'h1357_9BDF;
    logic [23:0] pal_model [256];

    always #2 clk = ~clk;

    line_unpacker u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .line_cols(line_cols),
        .line_go(line_go), .base_addr(base_addr), .frame_addr(frame_addr),
        .line_bytes(line_bytes), .pal_we(pal_we), .pal_addr(pal_addr),
        .pal_wdata(pal_wdata), .word_data(word_data), .word_vld(word_vld),
        .word_rdy(word_rdy), .pix_rdy(pix_rdy), .pix_vld(pix_vld),
        .pix_rgb(pix_rgb), .pix_last(pix_last)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return {seed[15:0], seed[31:16]};
    endfunction

    function automatic logic [23:0] exp_color(input int code, input bit swap, input logic [31:0] f);
        logic [7:0] r, g, b;
        logic [23:0] c;
        if (code <= 3) begin
            c = pal_model[f[7:0]];
            r = c[23:16]; g = c[15:8]; b = c[7:0];
        end else if (code == 4) begin
            r = {f[4:0], 3'b0}; g = {f[10:5], 2'b0}; b = {f[15:11], 3'b0};
        end else begin
            r = f[7:0]; g = f[15:8]; b = f[23:16];
        end
        return swap ? {b, g, r} : {r, g, b};
    endfunction

    // one line; ord: 0 none, 1 bit9, 2 bit10, 3 both
    task automatic run_line(input int code_in, input bit swap, input int ord, input int cols,
                            input bit stall, input bit chk_rate, input string req);
        int code, bpp, ppw, ppb, nwords, pos, wi, n, cyc, first_cyc, last_cyc;
        bit stalled_prev;
        logic [23:0] held_rgb;
        logic [31:0] fld [256];
        logic [31:0] wbuf [64];
        code = (code_in > 5) ? 5 : code_in;
        bpp = 1 << code;
        ppw = 32 / bpp;
        ppb = (bpp < 8) ? 8 / bpp : 1;
        nwords = (cols + ppw - 1) / ppw;
        for (int w = 0; w < 64; w++) wbuf[w] = '0;
        for (int k = 0; k < nwords * ppw; k++) begin
            logic [31:0] m;
            m = (bpp == 32) ? 32'hFFFF_FFFF : ((32'd1 << bpp) - 32'd1);
            fld[k] = rnd() & m;
            if (ord == 1 || ord == 3)
                pos = 32 - ((k % ppw) + 1) * bpp;
            else if (ord == 2 && bpp < 8)
                pos = ((k % ppw) / ppb) * 8 + 8 - (((k % ppw) % ppb) + 1) * bpp;
            else
                pos = (k % ppw) * bpp;
            wbuf[k / ppw] = wbuf[k / ppw] | (fld[k] << pos);
        end
        @(negedge clk);
        ctrl_word = 11'(code_in << 1) | (11'(swap) << 8) |
                    ((ord == 1 || ord == 3) ? 11'h200 : 11'h0) |
                    ((ord == 2 || ord == 3) ? 11'h400 : 11'h0);
        line_cols = 12'(cols);
        line_go = 1'b1;
        @(negedge clk);
        line_go = 1'b0;
        wi = 0; n = 0; cyc = 0; first_cyc = 0; last_cyc = 0; stalled_prev = 0; held_rgb = '0;
        forever begin
            pix_rdy  = stall ? (((cyc * 7 + 3) % 5) != 0) : 1'b1;
            word_vld = (wi < nwords) && (stall ? (((cyc * 3) % 4) != 0) : 1'b1);
            word_data = (wi < nwords) ? wbuf[wi] : 32'hDEAD_BEEF;
            #1;
            if (stalled_prev)
                check(pix_vld && pix_rgb == held_rgb, {req, " R10 hold"}, 64'(pix_rgb), 64'(held_rgb));
            stalled_prev = pix_vld && !pix_rdy;
            held_rgb = pix_rgb;
            if (word_vld && word_rdy) wi++;
            if (pix_vld && pix_rdy) begin
                logic [23:0] e;
                e = exp_color(code, swap, fld[n]);
                check(pix_rgb == e, req, 64'(pix_rgb), 64'(e));
                check(pix_last == (n == cols - 1), "R9 last flag", 64'(pix_last), 64'(n == cols - 1));
                if (n == 0) first_cyc = cyc;
                last_cyc = cyc;
                n++;
                if (pix_last || n >= cols) begin
                    @(negedge clk);
                    break;
                end
            end
            cyc++;
            if (cyc > 5000) begin
                check(0, {req, " R9 line hang"}, 64'(n), 64'(cols));
                break;
            end
            @(negedge clk);
        end
        check(n == cols, "R9 pixel count", 64'(n), 64'(cols));
        check(wi == nwords, "R9 words consumed", 64'(wi), 64'(nwords));
        word_vld = 1'b1; pix_rdy = 1'b1;
        #1;
        check(!word_rdy && !pix_vld, "R9 idle after line", 64'({word_rdy, pix_vld}), 64'(0));
        word_vld = 1'b0;
        if (chk_rate)
            check(last_cyc - first_cyc == cols - 1, "R13 consecutive pixels",
                  64'(last_cyc - first_cyc), 64'(cols - 1));
    endtask

    task automatic t_reset();
        word_vld = 1'b1; pix_rdy = 1'b1;
        repeat (3) @(negedge clk);
        check(!pix_vld && !word_rdy, "R1 in reset", 64'({pix_vld, word_rdy}), 64'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(!pix_vld && !word_rdy, "R1 after reset", 64'({pix_vld, word_rdy}), 64'(0));
        word_vld = 1'b0;
    endtask

    task automatic t_fill_palette();
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pal_model[i] = {8'(i), ~8'(i), 8'(i) ^ 8'h3C};
            pal_we = 1'b1; pal_addr = 8'(i); pal_wdata = pal_model[i];
        end
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    task automatic t_depths_le();
        for (int c = 0; c < 6; c++)
            run_line(c, 0, 0, 64, 0, 0, "R2 R3 R6 R7 little-endian depth");
        run_line(6, 0, 0, 10, 0, 0, "R2 code 6 as 32");
        run_line(7, 0, 0, 10, 0, 0, "R2 code 7 as 32");
    endtask

    task automatic t_be_byte();
        run_line(0, 0, 1, 64, 0, 0, "R4 big-endian 1bpp");
        run_line(2, 0, 3, 40, 0, 0, "R4 both bits 4bpp");
        run_line(4, 0, 3, 12, 0, 0, "R4 both bits 16bpp");
    endtask

    task automatic t_be_pix();
        run_line(0, 0, 2, 64, 0, 0, "R5 pixel order 1bpp");
        run_line(1, 0, 2, 48, 0, 0, "R5 pixel order 2bpp");
        run_line(3, 0, 2, 16, 0, 0, "R5 no effect 8bpp");
        run_line(4, 0, 2, 16, 0, 0, "R5 no effect 16bpp");
    endtask

    task automatic t_swap();
        run_line(3, 1, 0, 20, 0, 0, "R8 swap palette");
        run_line(4, 1, 0, 20, 0, 0, "R8 swap 16bpp");
        run_line(5, 1, 1, 20, 0, 0, "R8 swap 32bpp");
    endtask

    task automatic t_partial_word();
        run_line(3, 0, 0, 6, 0, 0, "R9 partial word");
        run_line(3, 0, 0, 5, 0, 0, "R9 next line fresh word");
        run_line(0, 0, 0, 1, 0, 0, "R9 single pixel");
    endtask

    task automatic t_stall();
        run_line(3, 0, 0, 48, 1, 0, "R10 stall 8bpp");
        run_line(1, 1, 2, 60, 1, 0, "R10 stall 2bpp");
    endtask

    task automatic t_rate();
        run_line(3, 0, 0, 64, 0, 1, "R13 rate 8bpp");
        run_line(5, 0, 0, 32, 0, 1, "R13 rate 32bpp");
    endtask

    task automatic t_line_bytes();
        int expv [8] = '{320/8, 320/4, 320/2, 320, 640, 1280, 1280, 1280};
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            ctrl_word = 11'(c << 1); line_cols = 12'd320;
            #1;
            check(line_bytes == 14'(expv[c]), "R11 line bytes", 64'(line_bytes), 64'(expv[c]));
        end
    endtask

    task automatic t_fold();
        logic [31:0] ins [4] = '{32'h8000_0000, 32'h8000_0001, 32'h0123_4560, 32'hFFFF_FFF0};
        logic [31:0] outs [4] = '{32'h8000_0000, 32'h0000_0001, 32'h0123_4560, 32'h7FFF_FFF0};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            base_addr = ins[i];
            #1;
            check(frame_addr == outs[i], "R12 address fold", 64'(frame_addr), 64'(outs[i]));
        end
    endtask

    initial begin
        #(200000 * 4);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_palette();
        t_depths_le();
        t_be_byte();
        t_be_pix();
        t_swap();
        t_partial_word();
        t_stall();
        t_rate();
        t_line_bytes();
        t_fold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule